// File: doc/BRIEF.md
# Horizontal sync jitter regenerator

This block sits in a video receive path right after the link decoder, on the pixel clock. Some transmitters place the horizontal sync pulse one pixel early or one pixel late from line to line, so the raw sync edge wanders over a two-clock span. Data enable (DE) stays fixed with respect to the pixel data. The block therefore uses DE as its only timing reference. It measures how far the raw sync leading edge lies from the end of active video, and how long the pulse lasts. It snaps both values to an 8-pixel grid and then rebuilds the horizontal sync from the delayed DE. A one-pixel wobble around a grid point never reaches the output.

Pixel data and DE travel through a fixed-length pipeline. The rebuilt horizontal and vertical sync leave the block with the same latency, so all outputs stay aligned. A new offset and width are taken only when two lines in a row give the same snapped values. Before the first such match after reset, the raw syncs pass through with the same delay as the data. The vertical sync is rebuilt as well: once regeneration is active, it changes state only at a rebuilt horizontal sync leading edge. Sync polarity is set by configuration inputs, and the outputs keep the polarity of the inputs.

Top module: `hsync_regen`

## Requirements
- R1: `out_de` and `out_data` equal `in_de` and `in_data` delayed by exactly LAT clocks (default 4).
- R2: While `locked` is 0, `out_hs` and `out_vs` equal `in_hs` and `in_vs` delayed by LAT clocks.
- R3: The offset is the number of clocks from the first clock with DE low to the first clock with sync active. It is 0 when both happen on the same clock, and it is counted only while DE stays low. The offset is rounded to the nearest multiple of 8, and a remainder of 4 rounds up (20 gives 24, 19 gives 16).
- R4: The pulse width is the number of clocks the raw sync is active. It is rounded in the same way as the offset and never goes below 8 (3 gives 8, 12 gives 16).
- R5: A snapped offset and width pair is adopted only when it equals the pair from the line just before. `locked` rises at the first adoption, and a single line with a different position leaves the output unchanged.
- R6: While `locked` is 1, `out_hs` is active on output blanking clocks offset through offset+width-1, counted from 0 at the first clock with `out_de` low. It is never active while `out_de` is high.
- R7: While `locked` is 1, `out_vs` changes only on the clock where the rebuilt horizontal sync becomes active. It then takes the value the delayed raw vertical sync has on that clock.
- R8: `cfg_hs_pol` and `cfg_vs_pol` select the active level of each sync, with 1 meaning active high and 0 meaning active low. The same level applies at the input and the output.
- R9: After reset, `out_de` is 0, `locked` is 0 and both syncs sit at their inactive level. Once `locked` is set, it stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hs_pol | input | 1 | Horizontal sync active level (1 = high) |
| cfg_vs_pol | input | 1 | Vertical sync active level (1 = high) |
| in_de | input | 1 | Data enable from decoder |
| in_hs | input | 1 | Raw horizontal sync |
| in_vs | input | 1 | Raw vertical sync |
| in_data | input | DW | Pixel data |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Regenerated horizontal sync |
| out_vs | output | 1 | Regenerated vertical sync |
| out_data | output | DW | Delayed pixel data |
| locked | output | 1 | Regeneration active |

## Verification
A wrong measurement count or a bad rounding step shows up as an `out_hs` pulse at the wrong blanking position. This appears on the first output line after the second matching input line, about one line period later. A broken agreement rule shows up either as `locked` rising after a single line, or as the glitch line moving the pulse on the very next line. A wrong delay stage skews `out_de` against `out_data` on the first active clock. A vertical sync that is latched at the wrong moment toggles away from a horizontal leading edge. The bench compares every output on every clock against a behavioural model, so each of these faults is caught on the cycle where it first appears.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    // Output sync positions are quantised to this many pixels.
    localparam int GRID = 8;

    // Round to the nearest grid point; the half-way value rounds up.
    function automatic logic [31:0] snap_grid(input logic [31:0] x);
        logic [31:0] t;
        t = x + 32'(GRID / 2);
        return t & ~32'(GRID - 1);
    endfunction
endpackage

// File: rtl/hsr_delay.sv
module hsr_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [DEPTH];
    logic [W-1:0] st_q [DEPTH];

    generate
        if (DEPTH == 1) begin : g_one
            always_comb st_d[0] = din;
        end else begin : g_chain
            always_comb begin
                st_d[0] = din;
                for (int i = 1; i < DEPTH; i++) st_d[i] = st_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
        end
    end

    assign dout = st_q[DEPTH-1];
endmodule

// File: rtl/hsr_meas.sv
module hsr_meas #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          de_i,
    input  logic          hs_i,
    output logic          locked_o,
    output logic [CW-1:0] off_o,
    output logic [CW-1:0] wid_o
);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] SMAX = CMAX & ~CW'(hsr_pkg::GRID - 1);
    localparam logic [CW-1:0] GSTEP = CW'(hsr_pkg::GRID);

    typedef struct packed {
        logic          de_p;
        logic          hs_p;
        logic          armed;
        logic          mval;
        logic          pval;
        logic          locked;
        logic [CW-1:0] cnt;
        logic [CW-1:0] oraw;
        logic [CW-1:0] po;
        logic [CW-1:0] pw;
        logic [CW-1:0] off;
        logic [CW-1:0] wid;
    } meas_t;

    meas_t d, q;

    function automatic logic [CW-1:0] snap_cl(input logic [CW-1:0] x);
        logic [31:0] s;
        s = hsr_pkg::snap_grid(32'(x));
        if (s > 32'(SMAX)) return SMAX;
        return s[CW-1:0];
    endfunction

    logic          fall, arm, rise, hfall, agree;
    logic [CW-1:0] cur, so, sw_r, sw;

    assign fall  = q.de_p & ~de_i;
    assign cur   = fall ? '0 : ((q.cnt == CMAX) ? CMAX : q.cnt + 1'b1);
    assign arm   = fall | (q.armed & ~de_i);
    assign rise  = hs_i & ~q.hs_p;
    assign hfall = ~hs_i & q.hs_p;
    assign so    = snap_cl(q.oraw);
    assign sw_r  = snap_cl(cur - q.oraw);
    assign sw    = (sw_r == '0) ? GSTEP : sw_r;
    assign agree = q.pval && (so == q.po) && (sw == q.pw);

    always_comb begin
        d = q;
        if (rise) begin
            if (arm) begin
                d.oraw = cur;
                d.mval = 1'b1;
            end else begin
                d.mval = 1'b0;
            end
        end else if (hfall && q.mval) begin
            if (agree) begin
                d.locked = 1'b1;
                d.off    = so;
                d.wid    = sw;
            end
            d.po   = so;
            d.pw   = sw;
            d.pval = 1'b1;
            d.mval = 1'b0;
        end
        d.de_p  = de_i;
        d.hs_p  = hs_i;
        d.cnt   = cur;
        d.armed = arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked_o = q.locked;
    assign off_o    = q.off;
    assign wid_o    = q.wid;

    // R9: lock is never lost without reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |=> q.locked);
    // R3: adopted offset lies on the grid
    a_r3_off_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |-> (q.off[2:0] == 3'd0));
    // R4: adopted width is a non-zero grid multiple
    a_r4_wid_min: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |-> (q.wid >= GSTEP && q.wid[2:0] == 3'd0));
endmodule

// File: rtl/hsr_gen.sv
module hsr_gen #(
    parameter int DW = 24,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked_i,
    input  logic [CW-1:0] off_i,
    input  logic [CW-1:0] wid_i,
    input  logic          de_i,
    input  logic          hs_i,
    input  logic          vs_i,
    input  logic [DW-1:0] data_i,
    output logic          de_o,
    output logic          hs_o,
    output logic          vs_o,
    output logic          lk_o,
    output logic [DW-1:0] data_o
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic          de;
        logic          hs;
        logic          vs;
        logic          lk;
        logic          gde_p;
        logic          garmed;
        logic          hsg_p;
        logic          vsr;
        logic [CW-1:0] gcnt;
        logic [DW-1:0] data;
    } gen_t;

    gen_t d, q;

    logic          gfall, garm, win, hsg, lead, vsr_n;
    logic [CW-1:0] gcur;
    logic [CW:0]   lo, hi, cc;

    assign gfall = q.gde_p & ~de_i;
    assign gcur  = gfall ? '0 : ((q.gcnt == CMAX) ? CMAX : q.gcnt + 1'b1);
    assign garm  = gfall | (q.garmed & ~de_i);
    assign cc    = {1'b0, gcur};
    assign lo    = {1'b0, off_i};
    assign hi    = {1'b0, off_i} + {1'b0, wid_i};
    assign win   = (cc >= lo) && (cc < hi);
    assign hsg   = locked_i & garm & win;
    assign lead  = hsg & ~q.hsg_p;
    assign vsr_n = (~locked_i | lead) ? vs_i : q.vsr;

    always_comb begin
        d        = q;
        d.de     = de_i;
        d.data   = data_i;
        d.hs     = locked_i ? hsg : hs_i;
        d.vs     = locked_i ? vsr_n : vs_i;
        d.lk     = locked_i;
        d.gde_p  = de_i;
        d.gcnt   = gcur;
        d.garmed = garm;
        d.hsg_p  = hsg;
        d.vsr    = vsr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign de_o   = q.de;
    assign hs_o   = q.hs;
    assign vs_o   = q.vs;
    assign lk_o   = q.lk;
    assign data_o = q.data;

    // R6: no regenerated sync during active video
    a_r6_no_hs_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lk && q.de) |-> !q.hs);
    // R7: vertical sync moves only with a horizontal leading edge
    a_r7_vs_at_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lk && $past(q.lk) && (q.vs != $past(q.vs))) |-> (q.hs && !$past(q.hs)));
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
    parameter int DW  = 24,
    parameter int CW  = 12,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic          in_de,
    input  logic          in_hs,
    input  logic          in_vs,
    input  logic [DW-1:0] in_data,
    output logic          out_de,
    output logic          out_hs,
    output logic          out_vs,
    output logic [DW-1:0] out_data,
    output logic          locked
);
    localparam int PW = DW + 3;

    logic          hs_a, vs_a, hs_o_a, vs_o_a;
    logic          m_lock;
    logic [CW-1:0] m_off, m_wid;
    logic [PW-1:0] pay_in, pay_out;

    // normalise to active-high inside the block
    assign hs_a   = cfg_hs_pol ? in_hs : ~in_hs;
    assign vs_a   = cfg_vs_pol ? in_vs : ~in_vs;
    assign pay_in = {in_data, in_de, hs_a, vs_a};

    hsr_meas #(.CW(CW)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .de_i     (in_de),
        .hs_i     (hs_a),
        .locked_o (m_lock),
        .off_o    (m_off),
        .wid_o    (m_wid)
    );

    hsr_delay #(.W(PW), .DEPTH(LAT - 1)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pay_in),
        .dout  (pay_out)
    );

    hsr_gen #(.DW(DW), .CW(CW)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked_i (m_lock),
        .off_i    (m_off),
        .wid_i    (m_wid),
        .de_i     (pay_out[2]),
        .hs_i     (pay_out[1]),
        .vs_i     (pay_out[0]),
        .data_i   (pay_out[PW-1:3]),
        .de_o     (out_de),
        .hs_o     (hs_o_a),
        .vs_o     (vs_o_a),
        .lk_o     (locked),
        .data_o   (out_data)
    );

    assign out_hs = cfg_hs_pol ? hs_o_a : ~hs_o_a;
    assign out_vs = cfg_vs_pol ? vs_o_a : ~vs_o_a;
endmodule

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
    localparam int DW = 24, CW = 12, LAT = 4;
    localparam int ACT = 32, BLK = 64, MAXC = 4095;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1;
    logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_de, out_hs, out_vs, locked;
    logic [DW-1:0] out_data;

    hsync_regen #(.DW(DW), .CW(CW), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_data(in_data),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_data(out_data),
        .locked(locked)
    );

    int total = 0, bad = 0;
    bit cmp_en = 0;
    logic [DW-1:0] dctr = '0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q_de[$], q_hs[$], q_vs[$];
    logic [DW-1:0] q_dat[$];
    bit g_dep, g_arm, g_hsp, g_vsr; int g_cnt;
    bit i_dep, i_hsp, i_arm, mval, pval, m_lock; int i_cnt, oraw, po, pw, m_off, m_wid;
    bit e_de, e_hs_a, e_vs_a, e_lk; logic [DW-1:0] e_dat;

    function automatic int snapv(input int x);
        return ((x + 4) / 8) * 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_de.delete(); q_hs.delete(); q_vs.delete(); q_dat.delete();
            for (int i = 0; i < LAT - 1; i++) begin
                q_de.push_back(0); q_hs.push_back(0); q_vs.push_back(0); q_dat.push_back('0);
            end
            g_dep = 0; g_arm = 0; g_hsp = 0; g_vsr = 0; g_cnt = 0;
            i_dep = 0; i_hsp = 0; i_arm = 0; mval = 0; pval = 0; m_lock = 0;
            i_cnt = 0; oraw = 0; po = 0; pw = 0; m_off = 0; m_wid = 0;
            e_de = 0; e_hs_a = 0; e_vs_a = 0; e_lk = 0; e_dat = '0;
        end else begin
            bit p_de, p_hs, p_vs, gfall, garm, hsg, lead, a_hs, a_vs, fall, arm;
            logic [DW-1:0] p_dat;
            int gcur, cur, so, sw;
            p_de = q_de.pop_front(); p_hs = q_hs.pop_front();
            p_vs = q_vs.pop_front(); p_dat = q_dat.pop_front();
            // output side, using parameters adopted before this edge
            gfall = g_dep && !p_de;
            gcur  = gfall ? 0 : ((g_cnt == MAXC) ? MAXC : g_cnt + 1);
            garm  = gfall || (g_arm && !p_de);
            hsg   = m_lock && garm && gcur >= m_off && gcur < m_off + m_wid;
            lead  = hsg && !g_hsp;
            if (!m_lock || lead) g_vsr = p_vs;
            e_hs_a = m_lock ? hsg : p_hs;
            e_vs_a = m_lock ? g_vsr : p_vs;
            e_lk = m_lock; e_de = p_de; e_dat = p_dat;
            g_dep = p_de; g_cnt = gcur; g_arm = garm; g_hsp = hsg;
            // input side measurement
            a_hs = cfg_hs_pol ? in_hs : !in_hs;
            a_vs = cfg_vs_pol ? in_vs : !in_vs;
            fall = i_dep && !in_de;
            cur  = fall ? 0 : ((i_cnt == MAXC) ? MAXC : i_cnt + 1);
            arm  = fall || (i_arm && !in_de);
            if (a_hs && !i_hsp) begin
                if (arm) begin oraw = cur; mval = 1; end
                else mval = 0;
            end else if (!a_hs && i_hsp && mval) begin
                so = snapv(oraw); sw = snapv(cur - oraw);
                if (sw == 0) sw = 8;
                if (pval && so == po && sw == pw) begin
                    m_lock = 1; m_off = so; m_wid = sw;
                end
                po = so; pw = sw; pval = 1; mval = 0;
            end
            i_dep = in_de; i_hsp = a_hs; i_cnt = cur; i_arm = arm;
            q_de.push_back(in_de); q_hs.push_back(a_hs); q_vs.push_back(a_vs); q_dat.push_back(in_data);
        end
    end

    // ---------------- output pulse monitor ----------------
    bit mon_dep, mon_hsp; int mon_cnt = 0, mon_ofs = -1, mon_wid = -1;

    task automatic compare();
        bit ehs, evs, ahs;
        ehs = cfg_hs_pol ? e_hs_a : !e_hs_a;
        evs = cfg_vs_pol ? e_vs_a : !e_vs_a;
        chk("R1 out_de", int'(out_de), int'(e_de));
        chk("R1 out_data", int'(out_data), int'(e_dat));
        if (!cfg_hs_pol)  chk("R8 out_hs low-active", int'(out_hs), int'(ehs));
        else if (e_lk)    chk("R6 out_hs regenerated", int'(out_hs), int'(ehs));
        else              chk("R2 out_hs passthrough", int'(out_hs), int'(ehs));
        if (e_lk) chk("R7 out_vs", int'(out_vs), int'(evs));
        else      chk("R2 out_vs passthrough", int'(out_vs), int'(evs));
        chk("R5 R9 locked", int'(locked), int'(e_lk));
        ahs = cfg_hs_pol ? out_hs : !out_hs;
        if (mon_dep && !out_de) mon_cnt = 0; else mon_cnt++;
        if (ahs && !mon_hsp) mon_ofs = mon_cnt;
        if (!ahs && mon_hsp) mon_wid = mon_cnt - mon_ofs;
        mon_dep = out_de; mon_hsp = ahs;
    endtask

    task automatic cyc(input bit de, input bit hsa, input bit vsa);
        @(negedge clk);
        if (cmp_en) compare();
        in_de = de;
        in_hs = cfg_hs_pol ? hsa : !hsa;
        in_vs = cfg_vs_pol ? vsa : !vsa;
        in_data = dctr;
        dctr = dctr + 24'h01_0203;
    endtask

    task automatic line(input int o, input int w, input bit v);
        for (int i = 0; i < ACT; i++) cyc(1, 0, v);
        for (int i = 0; i < BLK; i++) cyc(0, (i >= o) && (i < o + w), v);
    endtask

    task automatic do_reset(input bit pol);
        @(negedge clk);
        rst_n = 0; cfg_hs_pol = pol; cfg_vs_pol = pol;
        in_de = 0; in_hs = !pol; in_vs = !pol;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset out_de", int'(out_de), 0);
        chk("R9 reset locked", int'(locked), 0);
        chk("R9 reset out_hs idle", int'(out_hs), int'(!pol));
        chk("R9 reset out_vs idle", int'(out_vs), int'(!pol));
        rst_n = 1;
        mon_dep = 0; mon_hsp = 0; mon_cnt = 0;
        cmp_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1);
        // jittered positions around 16, width around 8
        line(15, 10, 0);
        line(17, 9, 0);
        line(16, 8, 0);
        chk("R3 jitter snapped offset", mon_ofs, 16);
        line(17, 7, 1);
        chk("R4 width snapped", mon_wid, 8);
        line(15, 9, 1);
        chk("R3 early jitter offset", mon_ofs, 16);
        line(16, 8, 0);
        // one bad line must not move the output
        line(40, 8, 0);
        chk("R5 glitch line keeps offset", mon_ofs, 16);
        line(16, 8, 0);
        chk("R5 line after glitch keeps offset", mon_ofs, 16);
        // remainder 4 rounds up
        line(20, 12, 0); line(20, 12, 0); line(20, 12, 1);
        chk("R3 remainder 4 rounds up", mon_ofs, 24);
        chk("R4 width remainder 4 rounds up", mon_wid, 16);
        // remainder 3 rounds down
        line(19, 11, 1); line(19, 11, 0); line(19, 11, 0);
        chk("R3 remainder 3 rounds down", mon_ofs, 16);
        chk("R4 width 11 snaps to 8", mon_wid, 8);
        line(20, 12, 0); line(20, 12, 0); line(20, 12, 0);
        // minimum width
        line(16, 3, 0); line(16, 3, 0); line(16, 3, 0);
        chk("R4 minimum width", mon_wid, 8);
        chk("R3 offset with short pulse", mon_ofs, 16);
        chk("R9 still locked", int'(locked), 1);
        // active-low syncs
        do_reset(0);
        line(16, 8, 0);
        chk("R2 no lock after one line", int'(locked), 0);
        line(16, 8, 1); line(17, 8, 1);
        chk("R8 low-active offset", mon_ofs, 16);
        chk("R8 low-active width", mon_wid, 8);
        line(15, 9, 0);
        chk("R8 low-active jitter offset", mon_ofs, 16);
        for (int i = 0; i < LAT + 4; i++) cyc(0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule